// File: doc/BRIEF.md
# Turbo Energy-Budget Frequency Governor

This block chooses the frequency step for a core domain whose cores share one clock. The operating system asks for a performance step. Index 0 is the fastest step, and larger indices are slower. Requests at the guaranteed step or slower are granted as asked. Requests faster than the guaranteed step are handled by the block itself. It keeps an energy reservoir that gains credit when the averaged package power is below the sustained power limit, and loses credit when the power is above it. The block spends this credit to climb into the turbo range, one step per evaluation interval. When the credit runs out, it falls back toward the guaranteed step.

The fastest step allowed depends on how many cores are active. Idle cores are power-gated, so their power share can go to the active cores. A small programmable table gives one turbo ceiling for each active-core count. Measured power is smoothed by a fixed-point exponential moving average, and a shift parameter sets how long the averaging window is. All updates happen on an evaluation-interval strobe. Measuring power, driving the PLL and changing the voltage are done outside this block.

Top module: `turbo_governor`

## Requirements
- R1: During reset and right after it, the granted step equals the guaranteed index. This index is TURBO_STEPS, which is 3 by default. The reservoir is empty and the power average is zero.
- R2: On a strobe where the requested index is at or above the guaranteed index, the grant becomes the requested index after that edge. A request above the slowest index PN_IDX is clamped to PN_IDX.
- R3: The grant changes only on edges where the strobe is high.
- R4: When the grant and the request are both at or faster than the guaranteed index, the grant moves by at most one index per strobe.
- R5: On each strobe, the reservoir level becomes old level + limit − new average. The result is held within 0 and the programmed capacity.
- R6: In turbo mode, the grant moves one index faster only when the updated reservoir level is strictly above the hysteresis threshold and the grant is slower than the target. The target is the slower of the request and the ceiling.
- R7: In turbo mode, if the updated reservoir level is zero and the grant is faster than the guaranteed index, the grant moves one index slower.
- R8: The turbo ceiling is the table entry for the active-core count. Entry k sits at bits [k*STEP_W +: STEP_W]. Counts above NCORES use entry NCORES, and entries slower than the guaranteed index act as the guaranteed index. A grant faster than the ceiling moves one index slower per strobe.
- R9: The average keeps an accumulator. On each strobe, acc ← acc + power − (acc >> AVG_SHIFT), and the average is acc >> AVG_SHIFT. The reservoir update on that strobe uses the new average.
- R10: On a strobe with a turbo request while the grant is slower than the guaranteed index, the grant jumps to the guaranteed index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eval_tick | input | 1 | Evaluation-interval strobe |
| req_step | input | STEP_W | Step requested by the OS (0 = fastest) |
| active_cnt | input | CORE_W | Number of cores not power-gated |
| pkg_power | input | PWR_W | Measured package power for this interval |
| power_limit | input | PWR_W | Sustained power limit |
| credit_cap | input | BUD_W | Reservoir capacity |
| rise_thresh | input | BUD_W | Level the reservoir must exceed before stepping faster |
| ceil_table | input | (NCORES+1)*STEP_W | Turbo ceiling per active-core count |
| grant_step | output | STEP_W | Granted frequency step |

## Verification
The bench first issues requests in the OS range, including one above the slowest index, to show that these bypass the reservoir. A long low-power phase then fills the reservoir up to its capacity. A sustained high-power turbo burst follows. It separates the climb gated by the threshold from the hold band and from the forced retreat at zero credit. Next, the active-core count is raised during turbo to show that the ceiling pulls the grant back. Finally, a turbo request made from a slow OS step separates the jump to the guaranteed step from a climb one step at a time. Gaps with no strobe show that the grant holds still between strobes.

// File: rtl/turbo_gov_pkg.sv
package turbo_gov_pkg;
   typedef enum logic [1:0] {
      MOVE_HOLD,
      MOVE_FASTER,
      MOVE_SLOWER,
      MOVE_LOAD
   } move_e;
endpackage

// File: rtl/tg_power_avg.sv
module tg_power_avg #(
   parameter int PWR_W     = 8,
   parameter int AVG_SHIFT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [PWR_W-1:0] sample,
   output logic [PWR_W-1:0] avg_new
);
   localparam int ACC_W = PWR_W + AVG_SHIFT;

   initial begin
      if (AVG_SHIFT < 1 || AVG_SHIFT > 8) $error("AVG_SHIFT out of range");
   end

   logic [ACC_W-1:0] acc_q, acc_nx;

   // acc never exceeds (2^PWR_W-1)<<AVG_SHIFT, so ACC_W bits suffice
   assign acc_nx  = acc_q - (acc_q >> AVG_SHIFT) + ACC_W'(sample);
   assign avg_new = acc_nx[ACC_W-1:AVG_SHIFT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc_q <= '0;
      else if (tick) acc_q <= acc_nx;
   end
endmodule

// File: rtl/tg_energy_bucket.sv
module tg_energy_bucket #(
   parameter int PWR_W = 8,
   parameter int BUD_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [PWR_W-1:0] limit,
   input  logic [PWR_W-1:0] avg_new,
   input  logic [BUD_W-1:0] cap,
   output logic [BUD_W-1:0] level,
   output logic [BUD_W-1:0] level_nx
);
   localparam int SUM_W = BUD_W + 2;

   initial begin
      if (BUD_W < PWR_W) $error("BUD_W must be at least PWR_W");
   end

   logic signed [SUM_W-1:0] sum;

   assign sum = $signed(SUM_W'(level)) + $signed(SUM_W'(limit))
              - $signed(SUM_W'(avg_new));

   always_comb begin
      if (sum < 0)                          level_nx = '0;
      else if (sum > $signed(SUM_W'(cap)))  level_nx = cap;
      else                                  level_nx = sum[BUD_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    level <= '0;
      else if (tick) level <= level_nx;
   end
endmodule

// File: rtl/tg_step_ctrl.sv
module tg_step_ctrl
   import turbo_gov_pkg::*;
#(
   parameter int STEP_W      = 4,
   parameter int TURBO_STEPS = 3,
   parameter int PN_IDX      = 9,
   parameter int NCORES      = 4,
   parameter int CORE_W      = 3,
   parameter int BUD_W       = 12
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         tick,
   input  logic [STEP_W-1:0]            req,
   input  logic [CORE_W-1:0]            active,
   input  logic [(NCORES+1)*STEP_W-1:0] table_in,
   input  logic [BUD_W-1:0]             thresh,
   input  logic [BUD_W-1:0]             credit_nx,
   output logic [STEP_W-1:0]            grant
);
   localparam logic [STEP_W-1:0] GUAR = STEP_W'(TURBO_STEPS);
   localparam logic [STEP_W-1:0] SLOW = STEP_W'(PN_IDX);
   localparam logic [CORE_W-1:0] TOPC = CORE_W'(NCORES);

   initial begin
      if (PN_IDX < TURBO_STEPS || PN_IDX >= (1 << STEP_W)) $error("bad PN_IDX");
      if (NCORES >= (1 << CORE_W)) $error("CORE_W too small");
   end

   logic [STEP_W-1:0] ceil_arr [NCORES+1];
   for (genvar k = 0; k <= NCORES; k++) begin : g_unpack
      assign ceil_arr[k] = table_in[k*STEP_W +: STEP_W];
   end

   logic [CORE_W-1:0] sel;
   logic [STEP_W-1:0] ceil_raw, ceil_c, req_c, tgt;
   move_e             move;

   assign sel      = (active > TOPC) ? TOPC : active;
   assign ceil_raw = ceil_arr[sel];
   assign ceil_c   = (ceil_raw > GUAR) ? GUAR : ceil_raw;
   assign req_c    = (req > SLOW) ? SLOW : req;
   assign tgt      = (req_c > ceil_c) ? req_c : ceil_c;

   always_comb begin
      if (req_c >= GUAR)                          move = MOVE_LOAD;
      else if (grant > GUAR)                      move = MOVE_LOAD;
      else if (grant < tgt)                       move = MOVE_SLOWER;
      else if (credit_nx == '0 && grant < GUAR)   move = MOVE_SLOWER;
      else if (grant > tgt && credit_nx > thresh) move = MOVE_FASTER;
      else                                        move = MOVE_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) grant <= GUAR;
      else if (tick) begin
         unique case (move)
            MOVE_LOAD:   grant <= (req_c >= GUAR) ? req_c : GUAR;
            MOVE_SLOWER: grant <= grant + STEP_W'(1);
            MOVE_FASTER: grant <= grant - STEP_W'(1);
            default:     grant <= grant;
         endcase
      end
   end
endmodule

// File: rtl/turbo_governor.sv
module turbo_governor #(
   parameter int STEP_W      = 4,
   parameter int TURBO_STEPS = 3,
   parameter int PN_IDX      = 9,
   parameter int NCORES      = 4,
   parameter int CORE_W      = $clog2(NCORES + 1),
   parameter int PWR_W       = 8,
   parameter int BUD_W       = 12,
   parameter int AVG_SHIFT   = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         eval_tick,
   input  logic [STEP_W-1:0]            req_step,
   input  logic [CORE_W-1:0]            active_cnt,
   input  logic [PWR_W-1:0]             pkg_power,
   input  logic [PWR_W-1:0]             power_limit,
   input  logic [BUD_W-1:0]             credit_cap,
   input  logic [BUD_W-1:0]             rise_thresh,
   input  logic [(NCORES+1)*STEP_W-1:0] ceil_table,
   output logic [STEP_W-1:0]            grant_step
);
   logic [PWR_W-1:0] avg_new;
   logic [BUD_W-1:0] credit_lvl, credit_nx;

   tg_power_avg #(.PWR_W(PWR_W), .AVG_SHIFT(AVG_SHIFT)) u_avg (
      .clk(clk), .rst_n(rst_n), .tick(eval_tick),
      .sample(pkg_power), .avg_new(avg_new));

   tg_energy_bucket #(.PWR_W(PWR_W), .BUD_W(BUD_W)) u_bucket (
      .clk(clk), .rst_n(rst_n), .tick(eval_tick),
      .limit(power_limit), .avg_new(avg_new), .cap(credit_cap),
      .level(credit_lvl), .level_nx(credit_nx));

   tg_step_ctrl #(.STEP_W(STEP_W), .TURBO_STEPS(TURBO_STEPS), .PN_IDX(PN_IDX),
                  .NCORES(NCORES), .CORE_W(CORE_W), .BUD_W(BUD_W)) u_step (
      .clk(clk), .rst_n(rst_n), .tick(eval_tick),
      .req(req_step), .active(active_cnt), .table_in(ceil_table),
      .thresh(rise_thresh), .credit_nx(credit_nx), .grant(grant_step));
endmodule

// File: rtl/turbo_governor_checker.sv
module turbo_governor_checker #(
   parameter int STEP_W      = 4,
   parameter int TURBO_STEPS = 3,
   parameter int PN_IDX      = 9,
   parameter int BUD_W       = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              eval_tick,
   input logic [STEP_W-1:0] req_step,
   input logic [BUD_W-1:0]  credit_cap,
   input logic [BUD_W-1:0]  rise_thresh,
   input logic [BUD_W-1:0]  credit_lvl,
   input logic [STEP_W-1:0] grant_step
);
   localparam logic [STEP_W-1:0] GUAR = STEP_W'(TURBO_STEPS);
   localparam logic [STEP_W-1:0] SLOW = STEP_W'(PN_IDX);
   localparam logic [STEP_W-1:0] ONE  = STEP_W'(1);

   AST_RESET_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> grant_step == GUAR); // R1

   AST_OS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      eval_tick && req_step >= GUAR && req_step <= SLOW
      |=> grant_step == $past(req_step)); // R2

   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !eval_tick |=> $stable(grant_step)); // R3

   AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      eval_tick && req_step < GUAR && grant_step <= GUAR
      |=> grant_step == $past(grant_step) || grant_step == $past(grant_step) + ONE
          || grant_step + ONE == $past(grant_step)); // R4

   AST_CREDIT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      eval_tick |=> credit_lvl <= $past(credit_cap)); // R5

   AST_RISE_NEEDS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
      eval_tick && req_step < GUAR && grant_step <= GUAR
      |=> grant_step >= $past(grant_step) || credit_lvl > $past(rise_thresh)); // R6

   AST_EMPTY_RETREAT: assert property (@(posedge clk) disable iff (!rst_n)
      eval_tick && req_step < GUAR && grant_step < GUAR
      |=> credit_lvl != '0 || grant_step == $past(grant_step) + ONE); // R7

   AST_ENTRY_GUAR: assert property (@(posedge clk) disable iff (!rst_n)
      eval_tick && req_step < GUAR && grant_step > GUAR
      |=> grant_step == GUAR); // R10
endmodule

bind turbo_governor turbo_governor_checker #(
   .STEP_W(STEP_W), .TURBO_STEPS(TURBO_STEPS), .PN_IDX(PN_IDX), .BUD_W(BUD_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .eval_tick(eval_tick), .req_step(req_step),
   .credit_cap(credit_cap), .rise_thresh(rise_thresh),
   .credit_lvl(credit_lvl), .grant_step(grant_step));

// File: tb/turbo_governor_test.sv
module turbo_governor_test;
   localparam int CLK_PERIOD = 10;
   localparam int STEP_W = 4, TURBO = 3, PN = 9, NC = 4, CW = 3;
   localparam int PW = 8, BW = 12, SH = 2;

   logic clk = 0, rst_n = 0, tick = 0;
   logic [STEP_W-1:0] req = 4'd3;
   logic [CW-1:0] act = 3'd1;
   logic [PW-1:0] pwr = 0, lim = 8'd40;
   logic [BW-1:0] cap = 12'd100, thr = 12'd8;
   // ceiling per active count 0..4 : 0,0,1,2,3
   logic [(NC+1)*STEP_W-1:0] tbl = {4'd3, 4'd2, 4'd1, 4'd0, 4'd0};
   logic [STEP_W-1:0] grant;

   turbo_governor uut (
      .clk(clk), .rst_n(rst_n), .eval_tick(tick), .req_step(req),
      .active_cnt(act), .pkg_power(pwr), .power_limit(lim), .credit_cap(cap),
      .rise_thresh(thr), .ceil_table(tbl), .grant_step(grant));

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct { int exp; string tag; } item_t;
   item_t sb[$];
   int n_cmp = 0, n_bad = 0;
   int m_acc = 0, m_bud = 0, m_g = TURBO;
   bit done = 0;

   task automatic check(int act_v, int exp_v, string tag);
      n_cmp++;
      if (act_v != exp_v) begin
         n_bad++;
         $display("FAIL %s: grant actual %0d expected %0d", tag, act_v, exp_v);
      end
   endtask

   // reference model of one evaluation interval
   task automatic model_step();
      int avg, rc, cl, ai, tg;
      m_acc = m_acc + int'(pwr) - (m_acc >> SH);          // R9
      avg = m_acc >> SH;
      m_bud = m_bud + int'(lim) - avg;                    // R5
      if (m_bud < 0) m_bud = 0;
      if (m_bud > int'(cap)) m_bud = int'(cap);
      rc = (int'(req) > PN) ? PN : int'(req);
      ai = (int'(act) > NC) ? NC : int'(act);
      cl = int'(tbl[ai*STEP_W +: STEP_W]);
      if (cl > TURBO) cl = TURBO;
      tg = (rc > cl) ? rc : cl;
      if (rc >= TURBO) m_g = rc;                          // R2
      else if (m_g > TURBO) m_g = TURBO;                  // R10
      else if (m_g < tg) m_g = m_g + 1;                   // R8
      else if (m_bud == 0 && m_g < TURBO) m_g = m_g + 1;  // R7
      else if (m_g > tg && m_bud > int'(thr)) m_g = m_g - 1; // R6
   endtask

   task automatic do_tick(int r, int a, int p, string tag);
      item_t it;
      @(negedge clk);
      req = STEP_W'(r); act = CW'(a); pwr = PW'(p); tick = 1;
      model_step();
      it.exp = m_g; it.tag = tag;
      sb.push_back(it);
      @(negedge clk);
      tick = 0;
   endtask

   // monitor: compare after every strobe edge
   initial begin
      forever begin
         @(posedge clk);
         if (tick) begin
            item_t it;
            #1;
            it = sb.pop_front();
            check(int'(grant), it.exp, it.tag);
         end
      end
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
      if (!done) begin
         n_bad++; n_cmp++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(int'(grant), TURBO, "R1 during reset");
      rst_n = 1;
      @(negedge clk);
      check(int'(grant), TURBO, "R1 after reset");
      // OS range requests
      do_tick(5, 1, 10, "R2 os step 5");
      do_tick(9, 1, 10, "R2 os step 9");
      do_tick(12, 1, 10, "R2 clamp to slowest");
      repeat (4) @(negedge clk);
      check(int'(grant), m_g, "R3 hold without strobe");
      // fill reservoir at low power
      for (int i = 0; i < 8; i++) do_tick(3, 1, 0, "R5 fill at guaranteed");
      // turbo burst, one core active
      for (int i = 0; i < 30; i++) do_tick(0, 1, 90, "R4 R6 R7 R9 burst");
      // recover credit at low power while requesting turbo
      for (int i = 0; i < 10; i++) do_tick(0, 1, 0, "R6 climb after refill");
      // more cores active: ceiling pulls grant back
      for (int i = 0; i < 4; i++) do_tick(0, 3, 0, "R8 ceiling three cores");
      do_tick(0, 4, 0, "R8 no turbo at four cores");
      do_tick(0, 7, 0, "R8 count above max");
      // turbo request from a slow step
      do_tick(8, 1, 0, "R2 to slow step");
      do_tick(0, 1, 0, "R10 jump to guaranteed");
      do_tick(0, 1, 0, "R6 first climb");
      repeat (3) @(negedge clk);
      check(int'(grant), m_g, "R3 hold in turbo");
      repeat (2) @(negedge clk);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule